// File: doc/BRIEF.md
# Eight-Phase Quarter-Rate Clock Generator with Quadrature Phase Selector

This block turns a fast input clock into a clock at one quarter of its rate and provides that slow clock in eight phases, each delayed by half an input period from the one before. Four of those phases, a quarter of the slow period apart, are routed to the sampling flops of a deserializer. A small offset select chooses which four phases are routed. A system can then move the sampling point in steps of half an input period, to make up for skew that changes with process corner.

The divider is a ring of four stages that feeds back inverted. It is modelled synthesizably, with one double-rate tick (`clk2x`) for each half input period. On every tick the ring moves one stage. The four stage outputs and their complements form the eight phases, and each phase is high for exactly half of the slow period. A new select value is loaded only on the tick where phase 0 rises. The outputs therefore switch phase only at a defined point in the slow cycle.

Top module: `phase_div8`

## Requirements
- R1: While `rst_n` is low, the ring holds all zeros. At a clock edge under reset, `phases` reads 8'hF0 and the active select is 0, so `quad` shows phases 0, 2, 4 and 6.
- R2: On every tick out of reset, phase k takes the previous value of phase k-1, and phase 0 takes the previous value of phase 7. The pattern repeats every eight ticks (four input periods). Counting ticks n from reset, phase k equals 1 exactly when (n-k) mod 8 is in {1,2,3,4}.
- R3: At all times exactly four of the eight phases are high, and phase k+4 is the complement of phase k. Every phase therefore has a 50% duty cycle.
- R4: With active select s, `quad[j]` equals phase (s+2j) mod 8 for j = 0..3. This gives outputs at 0°, 90°, 180° and 270°, counted from the chosen phase.
- R5: `phase_sel` is loaded into the active select only on the tick where phase 0 goes from 0 to 1. This is the tick taken from the ring's all-zero state. The first tick after reset is always such a tick.
- R6: A change of `phase_sel` between two load ticks has no effect on `quad` until the next load tick. If `phase_sel` changes several times in one period, only the value present at the load tick is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Tick at twice the input clock rate, one tick per half input period |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_sel | input | 3 | Requested phase offset, in half-input-period steps |
| quad | output | 4 | Quadrature sampling phases, starting at the selected offset |
| phases | output | 8 | All eight raw ring phases, for observation |

## Verification
The properties assume that reset is applied at least once before the outputs are relied on. They also assume that `phase_sel` changes only between ticks and never at a `clk2x` edge. The relation between the `quad` bits is checked only across windows in which the active select did not change. The bench meets these assumptions in two ways. It starts with reset asserted, and it drives `phase_sel` and `rst_n` only on falling edges of `clk2x`. In the course of the run, select changes fall at several positions within the eight-tick period. Some periods contain two changes, and one reset is applied in the middle of the run.

// File: rtl/phase_div8.sv
module phase_div8 #(
  parameter int STAGES = 4,
  localparam int NPH   = 2 * STAGES,
  localparam int SW    = $clog2(NPH),
  localparam int NQ    = 4,
  localparam int QSTEP = NPH / NQ
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic [SW-1:0] phase_sel,
  output logic [NQ-1:0] quad,
  output logic [NPH-1:0] phases
);

  logic [STAGES-1:0] ring;
  logic [SW-1:0]     sel_q;
  logic              launch;

  // phase 0 rises on the tick leaving the all-zero state
  assign launch = ~ring[STAGES-1] & ~ring[0];

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      ring  <= '0;
      sel_q <= '0;
    end else begin
      ring <= {ring[STAGES-2:0], ~ring[STAGES-1]};
      if (launch) sel_q <= phase_sel;
    end
  end

  assign phases = {~ring, ring};

  for (genvar j = 0; j < NQ; j++) begin : g_quad
    logic [SW-1:0] idx;
    assign idx     = sel_q + SW'(j * QSTEP);
    assign quad[j] = phases[idx];
  end

endmodule

// File: rtl/phase_div8_chk.sv
module phase_div8_chk #(
  parameter int STAGES = 4,
  localparam int NPH   = 2 * STAGES,
  localparam int SW    = $clog2(NPH)
) (
  input logic           clk2x,
  input logic           rst_n,
  input logic [NPH-1:0] phases,
  input logic [3:0]     quad,
  input logic [SW-1:0]  sel_act
);

  a_r1_reset_state: assert property (@(posedge clk2x)
    !rst_n |=> (!rst_n |-> (phases == {{STAGES{1'b1}}, {STAGES{1'b0}}} && sel_act == '0)));

  a_r2_ring_step: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) |-> phases == {$past(phases[NPH-2:0]), $past(phases[NPH-1])});

  a_r3_half_high: assert property (@(posedge clk2x) disable iff (!rst_n)
    $countones(phases) == STAGES);

  a_r3_complement: assert property (@(posedge clk2x) disable iff (!rst_n)
    phases[NPH-1:STAGES] == ~phases[STAGES-1:0]);

  a_r4_opposite: assert property (@(posedge clk2x) disable iff (!rst_n)
    quad[2] == ~quad[0] && quad[3] == ~quad[1]);

  a_r4_quarter_lag: assert property (@(posedge clk2x) disable iff (!rst_n)
    ($past(rst_n, 2) && $stable(sel_act) && $past($stable(sel_act)))
      |-> (quad[1] == $past(quad[0], 2) && quad[2] == $past(quad[1], 2)));

  a_r5_load_on_rise: assert property (@(posedge clk2x) disable iff (!rst_n)
    !$stable(sel_act) |-> $rose(phases[0]));

endmodule

bind phase_div8 phase_div8_chk #(.STAGES(STAGES)) u_chk (
  .clk2x   (clk2x),
  .rst_n   (rst_n),
  .phases  (phases),
  .quad    (quad),
  .sel_act (sel_q)
);

// File: tb/test_phase_div8.sv
module test_phase_div8;
  localparam int TCLK = 10;

  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] phase_sel = 3'd0;
  logic [3:0] quad;
  logic [7:0] phases;

  int compared = 0;
  int mismatched = 0;
  int n = 0;
  int act = 0;

  phase_div8 i_phase_div8 (
    .clk2x(clk2x), .rst_n(rst_n), .phase_sel(phase_sel),
    .quad(quad), .phases(phases)
  );

  always #(TCLK/2) clk2x = ~clk2x;

  function automatic logic ph(int tick);
    int m;
    m = ((tick % 8) + 8) % 8;
    return (m >= 1 && m <= 4);
  endfunction

  task automatic compare(string tag);
    logic [7:0] ep;
    logic [3:0] eq;
    for (int k = 0; k < 8; k++) ep[k] = ph(n - k);
    for (int j = 0; j < 4; j++) eq[j] = ph(n - ((act + 2*j) % 8));
    compared++;
    if (phases !== ep) begin
      mismatched++;
      $display("FAIL %s phases: got %b expected %b", tag, phases, ep);
    end
    compared++;
    if ($countones(phases) != 4 || phases[7:4] !== ~phases[3:0]) begin
      mismatched++;
      $display("FAIL R3 duty: got %b expected four high, complementary halves", phases);
    end
    compared++;
    if (quad !== eq) begin
      mismatched++;
      $display("FAIL R4/R5/R6 quad (sel %0d): got %b expected %b", act, quad, eq);
    end
  endtask

  task automatic step(int count);
    for (int i = 0; i < count; i++) begin
      @(posedge clk2x);
      if (!rst_n) begin
        n = 0; act = 0;
      end else begin
        if (n % 8 == 0) act = phase_sel;
        n = n + 1;
      end
      @(negedge clk2x);
      compare(rst_n ? "R2" : "R1");
    end
  endtask

  initial begin
    #(TCLK * 150000);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    phase_sel = 3'd5;
    step(3);
    rst_n = 1'b1;
    phase_sel = 3'd3;
    step(20);
    // R6: change mid-period, takes effect at next phase-0 rise
    step(2);
    phase_sel = 3'd5;
    step(16);
    // R4: every select value, changed at shifting positions
    for (int s = 0; s < 8; s++) begin
      phase_sel = 3'(s);
      step(9 + s);
    end
    // R6: two changes in one period, only the last is loaded
    step(3);
    phase_sel = 3'd6;
    step(2);
    phase_sel = 3'd1;
    step(12);
    // R5: change right before the load tick
    step(8 - (n % 8));
    phase_sel = 3'd7;
    step(10);
    // R1: reset mid-run
    rst_n = 1'b0;
    phase_sel = 3'd2;
    step(2);
    rst_n = 1'b1;
    step(12);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule